// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in hertz, the frequencies that a clock-control tree would produce from its current configuration fields. A fixed 24 MHz oscillator feeds a system PLL, with a multiplier of 20 or 22, and a USB PLL, always ×20. Two phase-fractional outputs scale the system PLL by 18/fraction. A chain of source muxes and divide-by-(field+1) stages then yields the peripheral, AHB, IPG and per-clock rates. Firmware models, timer setup logic or a monitor can request a recalculation whenever the configuration fields change.

A one-cycle `start` pulse latches every field and begins the walk down the tree. The divisions run one after another through a single restoring shift-subtract divider, which produces one quotient bit per clock. When the walk ends, `done` pulses for one cycle. The four frequencies and two error flags then hold until the next calculation completes. A `start` that arrives while `busy` is high has no effect.

Top module: `clk_tree_calc`

## Requirements
- R1: After reset, `busy` and `done` are 0, all four frequency outputs are 0, and both error flags are 0.
- R2: With `periph_sel`=0 and `pre_sel`=0, the peripheral frequency equals the system PLL: 528,000,000 Hz when `sys_mul_sel`=1 and 480,000,000 Hz when it is 0.
- R3: With `periph_sel`=0, `pre_sel`=1 gives (system PLL × 18) / `pfd2_frac`, and `pre_sel`=2 gives (system PLL × 18) / `pfd0_frac`, each with integer truncation.
- R4: With `periph_sel`=0 and `pre_sel`=3, the peripheral frequency is the `pfd2_frac` result of R3 halved, with truncation.
- R5: With `periph_sel`=1, the source picked by `alt_sel` is divided by (`alt_div`+1). The sources are: code 0 the USB PLL (480,000,000 Hz), code 1 the oscillator (24,000,000 Hz), code 2 a bypass source of value 0.
- R6: With `periph_sel`=1 and `alt_sel`=3 (reserved), the peripheral frequency is 0 and `rsvd_err` is 1. In every other case `rsvd_err` is 0.
- R7: When the selected fraction field is 0, the peripheral frequency is 0 and `frac_err` is 1. A zero fraction field on a path that is not selected leaves `frac_err` at 0.
- R8: The AHB frequency is the peripheral frequency / (`ahb_div`+1), and the IPG frequency is the AHB frequency / (`ipg_div`+1).
- R9: The per-clock frequency is (IPG frequency when `per_sel`=0, oscillator when `per_sel`=1) / (`per_div`+1).
- R10: `done` is high for exactly one cycle per accepted `start`, with `busy` low in that cycle. The outputs do not change between two `done` pulses. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (one-cycle pulse) |
| sys_mul_sel | input | 1 | System PLL multiplier: 1 selects ×22, 0 selects ×20 |
| pfd0_frac | input | FRAC_W (6) | Fraction field of fractional output 0 |
| pfd2_frac | input | FRAC_W (6) | Fraction field of fractional output 2 |
| pre_sel | input | 2 | Pre-peripheral mux code |
| alt_sel | input | 2 | Second peripheral mux code |
| periph_sel | input | 1 | 0 selects the pre-peripheral path, 1 the second path |
| alt_div | input | ALT_DIV_W (3) | Post-divider field of the second path |
| ahb_div | input | AHB_DIV_W (3) | AHB divider field |
| ipg_div | input | IPG_DIV_W (2) | IPG divider field |
| per_sel | input | 1 | Per-clock source: 0 IPG, 1 oscillator |
| per_div | input | PER_DIV_W (6) | Per-clock divider field |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| frac_err | output | 1 | Selected fraction field was zero |
| rsvd_err | output | 1 | Reserved second-mux code was selected |
| periph_hz | output | HZ_W (64) | Peripheral frequency in Hz |
| ahb_hz | output | HZ_W (64) | AHB frequency in Hz |
| ipg_hz | output | HZ_W (64) | IPG frequency in Hz |
| per_hz | output | HZ_W (64) | Per-clock frequency in Hz |

## Verification
Every stage feeds the next, so a wrong latched field, a wrong mux leg or a misplaced capture corrupts the peripheral value and carries down into the AHB, IPG and per-clock results. The fault shows at the ports at the `done` pulse of that same calculation, which comes a few hundred cycles after `start`. A divider that mis-counts its iterations gives wrong quotients in every stage. A sequencer that does not return to idle shows as a missing `done`, and a sequencer that accepts a second `start` shows as an extra `done`. In both cases the fault is visible within one calculation time.

// File: rtl/clk_calc_pkg.sv
package clk_calc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PERI,
      ST_AHB,
      ST_IPG,
      ST_PER,
      ST_FIN
   } calc_state_e;

   // pre-peripheral mux codes
   localparam logic [1:0] PRE_SYS      = 2'd0;
   localparam logic [1:0] PRE_F2       = 2'd1;
   localparam logic [1:0] PRE_F0       = 2'd2;
   localparam logic [1:0] PRE_F2_HALF  = 2'd3;

   // second peripheral mux codes
   localparam logic [1:0] ALT_USB      = 2'd0;
   localparam logic [1:0] ALT_OSC      = 2'd1;
   localparam logic [1:0] ALT_BYP      = 2'd2;
   localparam logic [1:0] ALT_RSVD     = 2'd3;

endpackage

// File: rtl/clk_calc_div.sv
module clk_calc_div #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quotient
);
   localparam int CW = $clog2(W + 1);

   if (W < 2) begin : g_bad_width
      $error("clk_calc_div: W must be at least 2");
   end

   logic [W:0]    rem_q;
   logic [W-1:0]  quo_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic          done_q;

   logic [W:0]    shifted;
   logic [W:0]    dext;
   logic          ge;

   always_comb begin
      shifted = {rem_q[W-1:0], quo_q[W-1]};
      dext    = {1'b0, divisor};
      ge      = (shifted >= dext) || rem_q[W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            rem_q <= '0;
            quo_q <= dividend;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= ge ? (shifted - dext) : shifted;
            quo_q <= {quo_q[W-2:0], ge};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done     = done_q;
   assign quotient = quo_q;

endmodule

// File: rtl/clk_calc_src.sv
module clk_calc_src
   import clk_calc_pkg::*;
#(
   parameter int          HZ_W       = 64,
   parameter int          FRAC_W     = 6,
   parameter logic [63:0] OSC_HZ     = 64'd24_000_000,
   parameter int          SYS_MUL_HI = 22,
   parameter int          SYS_MUL_LO = 20,
   parameter int          USB_MUL    = 20,
   parameter int          PFD_SCALE  = 18
) (
   input  logic              sys_mul_sel,
   input  logic [FRAC_W-1:0] pfd0_frac,
   input  logic [FRAC_W-1:0] pfd2_frac,
   input  logic [1:0]        pre_sel,
   input  logic [1:0]        alt_sel,
   output logic [HZ_W-1:0]   osc_hz,
   output logic [HZ_W-1:0]   sys_hz,
   output logic [HZ_W-1:0]   pfd_num,
   output logic [HZ_W-1:0]   pfd_den,
   output logic              frac_zero,
   output logic [HZ_W-1:0]   alt_hz,
   output logic              alt_rsvd
);
   localparam logic [HZ_W-1:0] OSC_C    = HZ_W'(OSC_HZ);
   localparam logic [HZ_W-1:0] SYS_HI_C = HZ_W'(OSC_HZ * 64'(SYS_MUL_HI));
   localparam logic [HZ_W-1:0] SYS_LO_C = HZ_W'(OSC_HZ * 64'(SYS_MUL_LO));
   localparam logic [HZ_W-1:0] USB_C    = HZ_W'(OSC_HZ * 64'(USB_MUL));
   localparam logic [HZ_W-1:0] SCALE_C  = HZ_W'(PFD_SCALE);

   logic [FRAC_W-1:0] frac_pick;

   always_comb begin
      osc_hz    = OSC_C;
      sys_hz    = sys_mul_sel ? SYS_HI_C : SYS_LO_C;
      pfd_num   = sys_hz * SCALE_C;
      frac_pick = (pre_sel == PRE_F0) ? pfd0_frac : pfd2_frac;
      pfd_den   = HZ_W'(frac_pick);
      frac_zero = (pre_sel != PRE_SYS) && (frac_pick == '0);
      alt_rsvd  = 1'b0;
      unique case (alt_sel)
         ALT_USB:  alt_hz = USB_C;
         ALT_OSC:  alt_hz = OSC_C;
         ALT_BYP:  alt_hz = '0;
         default: begin
            alt_hz   = '0;
            alt_rsvd = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/clk_tree_calc.sv
module clk_tree_calc
   import clk_calc_pkg::*;
#(
   parameter int          HZ_W       = 64,
   parameter int          FRAC_W     = 6,
   parameter int          ALT_DIV_W  = 3,
   parameter int          AHB_DIV_W  = 3,
   parameter int          IPG_DIV_W  = 2,
   parameter int          PER_DIV_W  = 6,
   parameter logic [63:0] OSC_HZ     = 64'd24_000_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 sys_mul_sel,
   input  logic [FRAC_W-1:0]    pfd0_frac,
   input  logic [FRAC_W-1:0]    pfd2_frac,
   input  logic [1:0]           pre_sel,
   input  logic [1:0]           alt_sel,
   input  logic                 periph_sel,
   input  logic [ALT_DIV_W-1:0] alt_div,
   input  logic [AHB_DIV_W-1:0] ahb_div,
   input  logic [IPG_DIV_W-1:0] ipg_div,
   input  logic                 per_sel,
   input  logic [PER_DIV_W-1:0] per_div,
   output logic                 busy,
   output logic                 done,
   output logic                 frac_err,
   output logic                 rsvd_err,
   output logic [HZ_W-1:0]      periph_hz,
   output logic [HZ_W-1:0]      ahb_hz,
   output logic [HZ_W-1:0]      ipg_hz,
   output logic [HZ_W-1:0]      per_hz
);
   localparam logic [HZ_W-1:0] ONE = HZ_W'(1);

   if (HZ_W < 40) begin : g_bad_hz_w
      $error("clk_tree_calc: HZ_W too narrow for PLL x fraction products");
   end
   if (FRAC_W < 1 || FRAC_W >= HZ_W) begin : g_bad_frac_w
      $error("clk_tree_calc: FRAC_W out of range");
   end
   if (ALT_DIV_W >= HZ_W || AHB_DIV_W >= HZ_W ||
       IPG_DIV_W >= HZ_W || PER_DIV_W >= HZ_W) begin : g_bad_div_w
      $error("clk_tree_calc: divider field wider than frequency word");
   end

   calc_state_e st_q;
   logic        issued_q;

   // latched configuration
   logic                 l_sys_sel, l_periph_sel, l_per_sel;
   logic [FRAC_W-1:0]    l_frac0, l_frac2;
   logic [1:0]           l_pre_sel, l_alt_sel;
   logic [ALT_DIV_W-1:0] l_alt_div;
   logic [AHB_DIV_W-1:0] l_ahb_div;
   logic [IPG_DIV_W-1:0] l_ipg_div;
   logic [PER_DIV_W-1:0] l_per_div;

   // working results
   logic [HZ_W-1:0] w_periph, w_ahb, w_ipg, w_per;
   logic            w_ferr, w_rerr;

   // published results
   logic [HZ_W-1:0] o_periph, o_ahb, o_ipg, o_per;
   logic            o_ferr, o_rerr, o_done;

   logic [HZ_W-1:0] osc_hz, sys_hz, pfd_num, pfd_den, alt_hz;
   logic            frac_zero, alt_rsvd;

   clk_calc_src #(
      .HZ_W   (HZ_W),
      .FRAC_W (FRAC_W),
      .OSC_HZ (OSC_HZ)
   ) src_i (
      .sys_mul_sel (l_sys_sel),
      .pfd0_frac   (l_frac0),
      .pfd2_frac   (l_frac2),
      .pre_sel     (l_pre_sel),
      .alt_sel     (l_alt_sel),
      .osc_hz      (osc_hz),
      .sys_hz      (sys_hz),
      .pfd_num     (pfd_num),
      .pfd_den     (pfd_den),
      .frac_zero   (frac_zero),
      .alt_hz      (alt_hz),
      .alt_rsvd    (alt_rsvd)
   );

   logic            pre_direct, pre_zero;
   logic            need_div, div_start, div_done;
   logic [HZ_W-1:0] dvd, dvs, quo, peri_q;

   always_comb begin
      pre_direct = !l_periph_sel && (l_pre_sel == PRE_SYS);
      pre_zero   = !l_periph_sel && frac_zero;
      dvd        = '0;
      dvs        = ONE;
      need_div   = 1'b0;
      unique case (st_q)
         ST_PERI: begin
            need_div = !pre_direct && !pre_zero;
            if (l_periph_sel) begin
               dvd = alt_hz;
               dvs = HZ_W'(l_alt_div) + ONE;
            end else begin
               dvd = pfd_num;
               dvs = pfd_den;
            end
         end
         ST_AHB: begin
            need_div = 1'b1;
            dvd      = w_periph;
            dvs      = HZ_W'(l_ahb_div) + ONE;
         end
         ST_IPG: begin
            need_div = 1'b1;
            dvd      = w_ahb;
            dvs      = HZ_W'(l_ipg_div) + ONE;
         end
         ST_PER: begin
            need_div = 1'b1;
            dvd      = l_per_sel ? osc_hz : w_ipg;
            dvs      = HZ_W'(l_per_div) + ONE;
         end
         default: ;
      endcase
      div_start = need_div && !issued_q;
      peri_q    = (!l_periph_sel && (l_pre_sel == PRE_F2_HALF)) ? (quo >> 1) : quo;
   end

   clk_calc_div #(.W(HZ_W)) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (dvd),
      .divisor  (dvs),
      .done     (div_done),
      .quotient (quo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         issued_q     <= 1'b0;
         l_sys_sel    <= 1'b0;
         l_periph_sel <= 1'b0;
         l_per_sel    <= 1'b0;
         l_frac0      <= '0;
         l_frac2      <= '0;
         l_pre_sel    <= '0;
         l_alt_sel    <= '0;
         l_alt_div    <= '0;
         l_ahb_div    <= '0;
         l_ipg_div    <= '0;
         l_per_div    <= '0;
         w_periph     <= '0;
         w_ahb        <= '0;
         w_ipg        <= '0;
         w_per        <= '0;
         w_ferr       <= 1'b0;
         w_rerr       <= 1'b0;
         o_periph     <= '0;
         o_ahb        <= '0;
         o_ipg        <= '0;
         o_per        <= '0;
         o_ferr       <= 1'b0;
         o_rerr       <= 1'b0;
         o_done       <= 1'b0;
      end else begin
         o_done <= 1'b0;
         if (div_start) begin
            issued_q <= 1'b1;
         end
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  l_sys_sel    <= sys_mul_sel;
                  l_periph_sel <= periph_sel;
                  l_per_sel    <= per_sel;
                  l_frac0      <= pfd0_frac;
                  l_frac2      <= pfd2_frac;
                  l_pre_sel    <= pre_sel;
                  l_alt_sel    <= alt_sel;
                  l_alt_div    <= alt_div;
                  l_ahb_div    <= ahb_div;
                  l_ipg_div    <= ipg_div;
                  l_per_div    <= per_div;
                  w_ferr       <= 1'b0;
                  w_rerr       <= 1'b0;
                  issued_q     <= 1'b0;
                  st_q         <= ST_PERI;
               end
            end
            ST_PERI: begin
               if (pre_direct) begin
                  w_periph <= sys_hz;
                  st_q     <= ST_AHB;
               end else if (pre_zero) begin
                  w_periph <= '0;
                  w_ferr   <= 1'b1;
                  st_q     <= ST_AHB;
               end else if (issued_q && div_done) begin
                  w_periph <= peri_q;
                  w_rerr   <= l_periph_sel && alt_rsvd;
                  issued_q <= 1'b0;
                  st_q     <= ST_AHB;
               end
            end
            ST_AHB: begin
               if (issued_q && div_done) begin
                  w_ahb    <= quo;
                  issued_q <= 1'b0;
                  st_q     <= ST_IPG;
               end
            end
            ST_IPG: begin
               if (issued_q && div_done) begin
                  w_ipg    <= quo;
                  issued_q <= 1'b0;
                  st_q     <= ST_PER;
               end
            end
            ST_PER: begin
               if (issued_q && div_done) begin
                  w_per    <= quo;
                  issued_q <= 1'b0;
                  st_q     <= ST_FIN;
               end
            end
            default: begin
               o_periph <= w_periph;
               o_ahb    <= w_ahb;
               o_ipg    <= w_ipg;
               o_per    <= w_per;
               o_ferr   <= w_ferr;
               o_rerr   <= w_rerr;
               o_done   <= 1'b1;
               st_q     <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign done      = o_done;
   assign frac_err  = o_ferr;
   assign rsvd_err  = o_rerr;
   assign periph_hz = o_periph;
   assign ahb_hz    = o_ahb;
   assign ipg_hz    = o_ipg;
   assign per_hz    = o_per;

endmodule

// File: rtl/clk_tree_calc_chk.sv
module clk_tree_calc_chk #(
   parameter int HZ_W = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic            frac_err,
   input logic            rsvd_err,
   input logic [HZ_W-1:0] periph_hz,
   input logic [HZ_W-1:0] ahb_hz,
   input logic [HZ_W-1:0] ipg_hz,
   input logic [HZ_W-1:0] per_hz
);
   // R10: completion is a single-cycle pulse
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: the sequencer is idle when it reports completion
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: an idle start is accepted
   a_r10_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R10: results hold between completions
   a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(periph_hz) && $stable(ahb_hz) && $stable(ipg_hz)
                 && $stable(per_hz) && $stable(frac_err) && $stable(rsvd_err)));

   // R8: each divide stage never raises the frequency
   a_r8_chain_order: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ahb_hz <= periph_hz && ipg_hz <= ahb_hz));

   // R7: a fraction error forces a zero peripheral frequency
   a_r7_zero_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      (done && frac_err) |-> (periph_hz == '0));

   // R6: the reserved code also yields zero
   a_r6_zero_on_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rsvd_err) |-> (periph_hz == '0 && !frac_err));

endmodule

bind clk_tree_calc clk_tree_calc_chk #(.HZ_W(HZ_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .frac_err  (frac_err),
   .rsvd_err  (rsvd_err),
   .periph_hz (periph_hz),
   .ahb_hz    (ahb_hz),
   .ipg_hz    (ipg_hz),
   .per_hz    (per_hz)
);

// File: tb/clk_tree_calc_tb_top.sv
`timescale 1ns/1ps
module clk_tree_calc_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sys_mul_sel = 1'b0;
   logic [5:0]  pfd0_frac = '0;
   logic [5:0]  pfd2_frac = '0;
   logic [1:0]  pre_sel = '0;
   logic [1:0]  alt_sel = '0;
   logic        periph_sel = 1'b0;
   logic [2:0]  alt_div = '0;
   logic [2:0]  ahb_div = '0;
   logic [1:0]  ipg_div = '0;
   logic        per_sel = 1'b0;
   logic [5:0]  per_div = '0;
   logic        busy, done, frac_err, rsvd_err;
   logic [63:0] periph_hz, ahb_hz, ipg_hz, per_hz;

   always #4 clk = ~clk;

   clk_tree_calc dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .sys_mul_sel(sys_mul_sel),
      .pfd0_frac(pfd0_frac), .pfd2_frac(pfd2_frac), .pre_sel(pre_sel),
      .alt_sel(alt_sel), .periph_sel(periph_sel), .alt_div(alt_div),
      .ahb_div(ahb_div), .ipg_div(ipg_div), .per_sel(per_sel),
      .per_div(per_div), .busy(busy), .done(done), .frac_err(frac_err),
      .rsvd_err(rsvd_err), .periph_hz(periph_hz), .ahb_hz(ahb_hz),
      .ipg_hz(ipg_hz), .per_hz(per_hz)
   );

   typedef struct {
      longint unsigned periph, ahb, ipg, per;
      bit              ferr, rerr;
      string           tag;
   } exp_t;

   exp_t exp_q[$];
   int   tests = 0;
   int   fails = 0;
   int   n_push = 0;
   int   n_pop = 0;
   bit   finished = 1'b0;
   bit   done_prev = 1'b0;

   localparam longint unsigned OSC = 64'd24_000_000;

   task automatic check(input bit ok, input string req, input string what,
                        input longint unsigned act, input longint unsigned expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic exp_t model(input int sm, input int f0, input int f2,
      input int pre, input int alt, input int psel, input int adiv,
      input int hdiv, input int idiv, input int qsel, input int qdiv,
      input string tag);
      exp_t e;
      longint unsigned sys, prod, src;
      e.ferr = 0; e.rerr = 0; e.tag = tag;
      sys  = OSC * (sm ? 64'd22 : 64'd20);
      prod = sys * 64'd18;
      if (psel == 0) begin
         case (pre)
            0: e.periph = sys;
            2: if (f0 == 0) begin e.periph = 0; e.ferr = 1; end
               else e.periph = prod / longint'(f0);
            default: begin
               if (f2 == 0) begin e.periph = 0; e.ferr = 1; end
               else e.periph = prod / longint'(f2);
               if (pre == 3) e.periph = e.periph / 2;
            end
         endcase
      end else begin
         case (alt)
            0: src = OSC * 64'd20;
            1: src = OSC;
            2: src = 0;
            default: begin src = 0; e.rerr = 1; end
         endcase
         e.periph = src / longint'(adiv + 1);
      end
      e.ahb = e.periph / longint'(hdiv + 1);
      e.ipg = e.ahb / longint'(idiv + 1);
      e.per = (qsel ? OSC : e.ipg) / longint'(qdiv + 1);
      return e;
   endfunction

   task automatic drive(input int sm, input int f0, input int f2,
      input int pre, input int alt, input int psel, input int adiv,
      input int hdiv, input int idiv, input int qsel, input int qdiv);
      sys_mul_sel = sm[0];    pfd0_frac = f0[5:0]; pfd2_frac = f2[5:0];
      pre_sel = pre[1:0];     alt_sel = alt[1:0];  periph_sel = psel[0];
      alt_div = adiv[2:0];    ahb_div = hdiv[2:0]; ipg_div = idiv[1:0];
      per_sel = qsel[0];      per_div = qdiv[5:0];
   endtask

   task automatic calc(input int sm, input int f0, input int f2,
      input int pre, input int alt, input int psel, input int adiv,
      input int hdiv, input int idiv, input int qsel, input int qdiv,
      input string tag);
      @(negedge clk);
      drive(sm, f0, f2, pre, alt, psel, adiv, hdiv, idiv, qsel, qdiv);
      exp_q.push_back(model(sm, f0, f2, pre, alt, psel, adiv, hdiv, idiv,
                            qsel, qdiv, tag));
      n_push++;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (n_pop < n_push) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on every completion
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && done_prev)
            check(1'b0, "R10", "done wider than one cycle", 2, 1);
         if (done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               n_pop++;
               check(periph_hz == e.periph, e.tag, "periph_hz", periph_hz, e.periph);
               check(ahb_hz == e.ahb, "R8", {e.tag, " ahb_hz"}, ahb_hz, e.ahb);
               check(ipg_hz == e.ipg, "R8", {e.tag, " ipg_hz"}, ipg_hz, e.ipg);
               check(per_hz == e.per, "R9", {e.tag, " per_hz"}, per_hz, e.per);
               check(frac_err == e.ferr, "R7", {e.tag, " frac_err"},
                     longint'(frac_err), longint'(e.ferr));
               check(rsvd_err == e.rerr, "R6", {e.tag, " rsvd_err"},
                     longint'(rsvd_err), longint'(e.rerr));
               check(!busy, "R10", "busy during done", longint'(busy), 0);
            end
         end
      end
      done_prev <= done;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      longint unsigned hold_p, hold_a, hold_i, hold_q;
      int dones_before;
      repeat (5) @(negedge clk);
      // R1: reset state
      check(busy == 0 && done == 0, "R1", "busy/done after reset",
            longint'({busy, done}), 0);
      check(periph_hz == 0 && ahb_hz == 0 && ipg_hz == 0 && per_hz == 0,
            "R1", "frequencies after reset", periph_hz | ahb_hz | ipg_hz | per_hz, 0);
      check(frac_err == 0 && rsvd_err == 0, "R1", "error flags after reset",
            longint'({frac_err, rsvd_err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      calc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");      // x22 no dividers
      calc(0, 0, 0, 0, 0, 0, 0, 3, 1, 0, 2, "R2");      // x20 with chain
      calc(1, 12, 24, 1, 0, 0, 0, 2, 1, 0, 0, "R3");    // frac2
      calc(1, 35, 24, 2, 0, 0, 0, 0, 3, 0, 5, "R3");    // frac0
      calc(0, 17, 13, 2, 3, 0, 7, 1, 2, 0, 1, "R3");    // odd truncation
      calc(1, 12, 16, 3, 0, 0, 0, 1, 1, 0, 0, "R4");    // halved frac2
      calc(1, 12, 19, 3, 0, 0, 0, 0, 0, 0, 0, "R4");    // odd halving
      calc(1, 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, "R5");      // usb /4
      calc(0, 0, 0, 0, 1, 1, 6, 2, 1, 0, 0, "R5");      // osc /7
      calc(1, 20, 20, 0, 2, 1, 0, 0, 0, 1, 0, "R5");    // bypass zero
      calc(1, 20, 20, 0, 3, 1, 2, 0, 0, 0, 0, "R6");    // reserved
      calc(1, 20, 20, 1, 3, 0, 0, 0, 0, 0, 0, "R6");    // code 3 unused path
      calc(1, 20, 0, 1, 0, 0, 0, 0, 0, 1, 3, "R7");     // selected frac zero
      calc(1, 0, 22, 1, 0, 0, 0, 0, 0, 0, 0, "R7");     // unselected zero
      calc(0, 0, 30, 2, 0, 0, 0, 0, 0, 0, 0, "R7");     // frac0 zero
      calc(1, 0, 0, 0, 0, 0, 0, 7, 3, 0, 63, "R8");     // max dividers
      calc(1, 18, 18, 1, 0, 0, 0, 5, 2, 1, 11, "R9");   // per from osc
      calc(0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 1, "R9");      // per from ipg

      // R10: outputs hold while inputs change without start
      hold_p = periph_hz; hold_a = ahb_hz; hold_i = ipg_hz; hold_q = per_hz;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         drive(k & 1, k, 63 - k, k & 3, (k >> 1) & 3, k & 1, k & 7, k & 7,
               k & 3, (k >> 2) & 1, k);
      end
      check(periph_hz == hold_p && ahb_hz == hold_a && ipg_hz == hold_i &&
            per_hz == hold_q, "R10", "outputs drifted without start",
            periph_hz ^ hold_p, 0);

      // R10: start while busy is ignored
      dones_before = n_pop;
      @(negedge clk);
      drive(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
      exp_q.push_back(model(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R10"));
      n_push++;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      check(busy == 1, "R10", "busy during calculation", longint'(busy), 1);
      drive(0, 12, 12, 1, 1, 1, 5, 4, 3, 1, 9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (n_pop < n_push) @(negedge clk);
      repeat (400) @(negedge clk);
      check(n_pop - dones_before == 1 && exp_q.size() == 0, "R10",
            "completions for one accepted start", n_pop - dones_before, 1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule